// File: doc/BRIEF.md
# Restorable Speculative Direction Counter Table

This block keeps a direct-mapped table of 2-bit saturating counters that predict the direction of conditional branches. The low bits of a branch address select the counter, so two branches whose addresses agree in those bits share one counter. A predict port returns taken or not-taken for an address in the same cycle. A resolve port trains the selected counter with the actual outcome.

While a speculative region is open, any resolve marked speculative still trains its counter at once. Later predictions inside the same region therefore see the update. Each such update also writes the counter's index and its value before the update into a small undo log. A squash strobe rolls back every logged counter and closes the region. By default a rolled-back counter returns to its exact value from before the region. A build-time option instead resets it to weakly not-taken, which is cheaper. A commit strobe keeps every update, clears the log and closes the region. A begin strobe opens a new region with an empty log.

Top module: `spec_pht`

## Requirements
- R1: After reset every counter holds weakly not-taken (code 01), so every address predicts not-taken.
- R2: Counter codes are 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. The prediction is bit 1 of the selected counter. A resolve is visible at the predict port in the cycle after its clock edge.
- R3: A taken outcome moves the counter up one step and stops at 11. A not-taken outcome moves it down one step and stops at 00.
- R4: The counter is selected by address bits [IDX_W-1:0] only. Addresses that differ only above those bits share a counter.
- R5: A speculative resolve inside an open region updates its counter immediately and adds one log record.
- R6: On squash with RESTORE_FIXED=0, every logged counter returns to the value it held before the region opened.
- R7: When several log records name one index, the restore uses the oldest record. The counter ends at its value from before the region, not at an intermediate value.
- R8: Commit clears the log and closes the region without changing any counter. A later squash undoes nothing from the committed region.
- R9: The log holds JRNL_DEPTH records (8 by default). When the log is full, a further speculative resolve is dropped and its counter is left unchanged.
- R10: A resolve with the speculative flag low is never logged and survives a squash. The same holds for a speculative-flagged resolve while no region is open.
- R11: A resolve in the same cycle as begin, squash or commit is ignored. A squash while no region is open changes no counter.
- R12: With RESTORE_FIXED=1, a squash sets every logged counter to weakly not-taken (01) instead of its prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_addr | input | ADDR_W | Address to predict |
| pred_taken | output | 1 | Predicted direction for pred_addr |
| res_valid | input | 1 | A resolved branch is presented |
| res_addr | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_spec | input | 1 | The resolved branch lies on a speculative path |
| spec_begin | input | 1 | Open a speculative region |
| spec_squash | input | 1 | Discard the open region and roll back its updates |
| spec_commit | input | 1 | Keep the open region's updates |

## Verification
The bench drives several kinds of pattern and compares predictions against a reference model built from the requirements.

- **Training runs** climb into and fall out of saturation. These separate correct stepping and clamping from wrap-around.
- **Aliased addresses** that differ only above the index bits show which bits select the counter.
- **A strongly taken counter pushed to strongly not-taken inside a region, then squashed,** separates exact restore from fixed reset. Two instances with opposite restore options run side by side.
- **Repeated updates to one counter within a region** expose a restore that uses the newest record instead of the oldest.
- **Filling the log, mixing non-speculative resolves into a region, and putting a resolve on the same cycle as a strobe** probe the drop, survive and ignore rules.

// File: rtl/spht_pkg.sv
// Package: shared counter encodings and the saturating step function.
// Assumes 2-bit counters whose bit 1 is the predicted direction.
package spht_pkg;
    localparam logic [1:0] CTR_SNT = 2'b00;
    localparam logic [1:0] CTR_WNT = 2'b01;
    localparam logic [1:0] CTR_WT  = 2'b10;
    localparam logic [1:0] CTR_ST  = 2'b11;

    // Move one step toward the outcome, clamping at both ends.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
        else       nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
        return nxt;
    endfunction
endpackage

// File: rtl/spht_table.sv
// Counter table: 2**IDX_W two-bit counters with two combinational read ports.
// It takes one write per cycle and a bulk rollback driven by the undo log.
// Assumes a write and a rollback never arrive in the same cycle. In a
// rollback, the lowest (oldest) log slot wins when slots share an index.
module spht_table
    import spht_pkg::*;
#(
    parameter int         IDX_W         = 6,
    parameter int         JDEPTH        = 8,
    parameter bit         RESTORE_FIXED = 1'b0,
    parameter logic [1:0] FIXED_VAL     = CTR_WNT
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_W-1:0]               rd_a_idx,
    output logic [1:0]                     rd_a_val,
    input  logic [IDX_W-1:0]               rd_b_idx,
    output logic [1:0]                     rd_b_val,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [1:0]                     wr_val,
    input  logic                           rb_en,
    input  logic [JDEPTH-1:0]              rb_valid,
    input  logic [JDEPTH-1:0][IDX_W-1:0]   rb_idx,
    input  logic [JDEPTH-1:0][1:0]         rb_old
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][1:0]  cnt;
    logic [DEPTH-1:0][1:0]  cnt_nxt;
    logic [JDEPTH-1:0][1:0] rb_fill;

    // Choose what a rolled-back counter receives: its logged value or a fixed state.
    generate
        if (RESTORE_FIXED) begin : g_fixed
            assign rb_fill = {JDEPTH{FIXED_VAL}};
            logic unused_rb_old;
            assign unused_rb_old = ^rb_old;
        end else begin : g_exact
            assign rb_fill = rb_old;
        end
    endgenerate

    // Read ports.
    assign rd_a_val = cnt[rd_a_idx];
    assign rd_b_val = cnt[rd_b_idx];

    // Next table contents: a single write, or a rollback walked newest to oldest.
    always_comb begin
        cnt_nxt = cnt;
        if (wr_en) cnt_nxt[wr_idx] = wr_val;
        if (rb_en) begin
            for (int j = JDEPTH - 1; j >= 0; j--) begin
                if (rb_valid[j]) cnt_nxt[rb_idx[j]] = rb_fill[j];
            end
        end
    end

    // Counter storage, reset to weakly not-taken.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= {DEPTH{CTR_WNT}};
        else        cnt <= cnt_nxt;
    end

    // Record the last plain write so the step-size check can look back at it.
    logic             last_wr;
    logic [IDX_W-1:0] last_idx;
    logic [1:0]       last_old;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_wr  <= 1'b0;
            last_idx <= '0;
            last_old <= CTR_WNT;
        end else begin
            last_wr  <= wr_en && !rb_en;
            last_idx <= wr_idx;
            last_old <= cnt[wr_idx];
        end
    end

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_wr |-> ((cnt[last_idx] == last_old) ||
                     (cnt[last_idx] == last_old + 2'd1 && last_old != CTR_ST) ||
                     (cnt[last_idx] == last_old - 2'd1 && last_old != CTR_SNT)));

    // R11
    no_wr_in_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rb_en));
endmodule

// File: rtl/spht_journal.sv
// Undo log: records {index, prior value} pairs in arrival order.
// Slot 0 is the oldest. A clear empties the log. Assumes the caller never
// pushes while the log is full and never pushes in the same cycle as a clear.
module spht_journal #(
    parameter int IDX_W  = 6,
    parameter int JDEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [IDX_W-1:0]              push_idx,
    input  logic [1:0]                    push_old,
    output logic                          full,
    output logic [JDEPTH-1:0]             valid,
    output logic [JDEPTH-1:0][IDX_W-1:0]  idx_q,
    output logic [JDEPTH-1:0][1:0]        old_q
);
    localparam int CNT_W = $clog2(JDEPTH + 1);

    logic [CNT_W-1:0] count;

    assign full = (count == CNT_W'(JDEPTH));

    // A slot is valid while it lies below the fill count.
    generate
        for (genvar g = 0; g < JDEPTH; g++) begin : g_valid
            assign valid[g] = (count > CNT_W'(g));
        end
    endgenerate

    // Fill count: cleared by clr, incremented by each push.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (push)     count <= count + 1'b1;
    end

    // Record storage: a push writes the slot at the current fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            old_q <= '0;
        end else begin
            for (int j = 0; j < JDEPTH; j++) begin
                if (push && count == CNT_W'(j)) begin
                    idx_q[j] <= push_idx;
                    old_q[j] <= push_old;
                end
            end
        end
    end

    // R9
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(JDEPTH));
endmodule

// File: rtl/spec_pht.sv
// Top: restorable speculative direction counter table.
// - Resolves inside an open region are applied at once and logged, so a
//   squash can undo them.
// - Strobe priority is squash, then commit, then begin.
// - Any resolve in a strobe cycle is ignored.
// - Only one region is open at a time; a begin inside an open region restarts it.
module spec_pht
    import spht_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int IDX_W         = 6,
    parameter int JRNL_DEPTH    = 8,
    parameter bit RESTORE_FIXED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic              res_taken,
    input  logic              res_spec,
    input  logic              spec_begin,
    input  logic              spec_squash,
    input  logic              spec_commit
);
    logic [IDX_W-1:0] pred_idx, res_idx;
    logic [1:0]       pred_val, res_old, res_new;
    logic             region_open, ctl_cycle, res_fire, logged, dropped;
    logic             wr_en, rb_en, jr_clr, jr_push, jr_full;
    logic [JRNL_DEPTH-1:0]            jr_valid;
    logic [JRNL_DEPTH-1:0][IDX_W-1:0] jr_idx;
    logic [JRNL_DEPTH-1:0][1:0]       jr_old;

    // Direct index from the low address bits; the high bits are not used.
    assign pred_idx = pred_addr[IDX_W-1:0];
    assign res_idx  = res_addr[IDX_W-1:0];
    logic unused_hi;
    assign unused_hi = ^{pred_addr[ADDR_W-1:IDX_W], res_addr[ADDR_W-1:IDX_W]};

    // Resolve handling: ignore in strobe cycles, log in a region, drop when the log is full.
    assign ctl_cycle = spec_begin | spec_squash | spec_commit;
    assign res_fire  = res_valid && !ctl_cycle;
    assign logged    = res_fire && res_spec && region_open;
    assign dropped   = logged && jr_full;
    assign jr_push   = logged && !jr_full;
    assign wr_en     = res_fire && !dropped;
    assign res_new   = ctr_step(res_old, res_taken);
    assign rb_en     = spec_squash && region_open;
    assign jr_clr    = ctl_cycle;
    assign pred_taken = pred_val[1];

    // Region state: squash or commit closes the region; begin opens it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          region_open <= 1'b0;
        else if (spec_squash || spec_commit) region_open <= 1'b0;
        else if (spec_begin)                 region_open <= 1'b1;
    end

    spht_table #(
        .IDX_W(IDX_W), .JDEPTH(JRNL_DEPTH),
        .RESTORE_FIXED(RESTORE_FIXED), .FIXED_VAL(CTR_WNT)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(pred_idx), .rd_a_val(pred_val),
        .rd_b_idx(res_idx), .rd_b_val(res_old),
        .wr_en(wr_en), .wr_idx(res_idx), .wr_val(res_new),
        .rb_en(rb_en), .rb_valid(jr_valid), .rb_idx(jr_idx), .rb_old(jr_old)
    );

    spht_journal #(.IDX_W(IDX_W), .JDEPTH(JRNL_DEPTH)) u_journal (
        .clk(clk), .rst_n(rst_n),
        .clr(jr_clr), .push(jr_push), .push_idx(res_idx), .push_old(res_old),
        .full(jr_full), .valid(jr_valid), .idx_q(jr_idx), .old_q(jr_old)
    );

    // R5
    log_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jr_push |=> $countones(jr_valid) == $countones($past(jr_valid)) + 1);

    // R8
    commit_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_commit |=> (jr_valid == '0) && !region_open);

    // R10
    closed_no_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!region_open && !spec_begin) |=> $stable(jr_valid));

    // R11
    squash_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_squash |=> !region_open && (jr_valid == '0));
endmodule

// File: tb/spec_pht_tb.sv
module spec_pht_tb;
    localparam int IDX_W = 6;
    localparam int DEPTH = 1 << IDX_W;
    localparam int JD    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_addr = '0;
    logic        res_valid = 1'b0, res_taken = 1'b0, res_spec = 1'b0;
    logic [31:0] res_addr = '0;
    logic        spec_begin = 1'b0, spec_squash = 1'b0, spec_commit = 1'b0;
    logic        pt_exact, pt_fixed;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference state from the requirements: [0] exact restore, [1] fixed reset.
    logic [1:0] m_cnt [2][DEPTH];
    bit         m_open;
    int         m_jn;
    int         m_jidx [JD];
    logic [1:0] m_jold [JD];

    always #2 clk = ~clk;

    spec_pht #(.RESTORE_FIXED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pt_exact),
        .res_valid(res_valid), .res_addr(res_addr), .res_taken(res_taken),
        .res_spec(res_spec), .spec_begin(spec_begin), .spec_squash(spec_squash),
        .spec_commit(spec_commit));

    spec_pht #(.RESTORE_FIXED(1'b1)) u_dut_fixed (
        .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pt_fixed),
        .res_valid(res_valid), .res_addr(res_addr), .res_taken(res_taken),
        .res_spec(res_spec), .spec_begin(spec_begin), .spec_squash(spec_squash),
        .spec_commit(spec_commit));

    function automatic logic [1:0] stepm(logic [1:0] c, logic t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    // One clock with the given inputs; starts and ends at a falling edge.
    task automatic cyc(bit rv, int addr, bit tk, bit sp, bit b, bit sq, bit cm);
        int ix;
        res_valid = rv; res_addr = addr; res_taken = tk; res_spec = sp;
        spec_begin = b; spec_squash = sq; spec_commit = cm;
        @(posedge clk);
        ix = addr % DEPTH;
        if (b || sq || cm) begin
            if (sq && m_open) begin
                for (int j = m_jn - 1; j >= 0; j--) begin
                    m_cnt[0][m_jidx[j]] = m_jold[j];
                    m_cnt[1][m_jidx[j]] = 2'b01;
                end
            end
            m_jn = 0;
            m_open = (sq || cm) ? 1'b0 : 1'b1;
        end else if (rv) begin
            if (sp && m_open) begin
                if (m_jn < JD) begin
                    m_jidx[m_jn] = ix; m_jold[m_jn] = m_cnt[0][ix]; m_jn++;
                    m_cnt[0][ix] = stepm(m_cnt[0][ix], tk);
                    m_cnt[1][ix] = stepm(m_cnt[1][ix], tk);
                end
            end else begin
                m_cnt[0][ix] = stepm(m_cnt[0][ix], tk);
                m_cnt[1][ix] = stepm(m_cnt[1][ix], tk);
            end
        end
        @(negedge clk);
        res_valid = 0; spec_begin = 0; spec_squash = 0; spec_commit = 0;
    endtask

    task automatic res(int addr, bit tk, bit sp);
        cyc(1, addr, tk, sp, 0, 0, 0);
    endtask

    // Compare both instances' predictions at index ix; exp_lit, if not -1, must also match.
    task automatic chk(int ix, string req, int exp_lit = -1);
        pred_addr = (32'h5A5 << IDX_W) | ix;
        #1;
        total++;
        if (pt_exact !== m_cnt[0][ix][1] || (exp_lit >= 0 && pt_exact !== exp_lit[0])) begin
            bad++;
            $display("FAIL %s idx=%0d exact actual=%0b expected=%0b", req, ix, pt_exact, m_cnt[0][ix][1]);
        end
        total++;
        if (pt_fixed !== m_cnt[1][ix][1]) begin
            bad++;
            $display("FAIL %s idx=%0d fixed actual=%0b expected=%0b", req, ix, pt_fixed, m_cnt[1][ix][1]);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < DEPTH; i += 9) chk(i, "R1", 0);
        res(2, 1, 0);
        chk(2, "R2", 1);
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 4; k++) res(5, 1, 0);
        chk(5, "R3", 1);
        res(5, 0, 0); chk(5, "R3", 1);
        res(5, 0, 0); chk(5, "R3", 0);
        for (int k = 0; k < 4; k++) res(5, 0, 0);
        res(5, 1, 0); chk(5, "R3", 0);
    endtask

    task automatic t_alias;
        res(32'h1C0 | 7, 1, 0);
        chk(7, "R4", 1);
    endtask

    task automatic t_spec_exact;
        cyc(0, 0, 0, 0, 1, 0, 0);
        res(10, 1, 1); chk(10, "R5", 1);
        cyc(0, 0, 0, 0, 0, 1, 0); chk(10, "R6", 0);
        for (int k = 0; k < 3; k++) res(12, 1, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 3; k++) res(12, 0, 1);
        chk(12, "R5", 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(12, "R6 R12", 1);
    endtask

    task automatic t_oldest;
        cyc(0, 0, 0, 0, 1, 0, 0);
        res(14, 1, 1); res(14, 1, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(14, "R7", 0);
    endtask

    task automatic t_commit;
        cyc(0, 0, 0, 0, 1, 0, 0);
        res(20, 1, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(20, "R8", 1);
    endtask

    task automatic t_full;
        cyc(0, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < JD; k++) res(30 + k, 1, 1);
        res(40, 1, 1);
        chk(40, "R9", 0);
        chk(37, "R9", 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(30, "R9", 0);
        chk(37, "R9", 0);
    endtask

    task automatic t_nonspec;
        cyc(0, 0, 0, 0, 1, 0, 0);
        res(44, 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(44, "R10", 1);
        res(45, 1, 1);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(45, "R10", 1);
    endtask

    task automatic t_ctl;
        cyc(1, 50, 1, 0, 1, 0, 0);
        chk(50, "R11", 0);
        cyc(1, 51, 1, 1, 0, 0, 1);
        chk(51, "R11", 0);
        res(52, 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(52, "R11", 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_cnt[0][i] = 2'b01; m_cnt[1][i] = 2'b01; end
        m_open = 0; m_jn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_saturate();
        t_alias();
        t_spec_exact();
        t_oldest();
        t_commit();
        t_full();
        t_nonspec();
        t_ctl();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule